// File: doc/BRIEF.md
# Fermat Probable-Prime Tester

This block decides whether an odd integer is probably prime by raising a fixed base to the power (candidate minus one), modulo the candidate, and checking whether the residue equals one. The modular power is formed by scanning the exponent from its top bit down to its bottom bit. Each scanned bit squares the running value. A bit that is set also multiplies the running value by the base. Every product passes through a bit-serial restoring divider, and only the remainder is kept.

A surrounding key-generation controller places a candidate of width `CAND_W` on the candidate input and pulses `enable`. When the test ends, `done` pulses for one cycle. The residue and the probable-prime flag then hold their values until the next test completes. Candidates that are even or smaller than three are refused at once, without any arithmetic. Candidate generation, storage of accepted primes and retrying are left to the caller.

Top module: `fermat_prime_tester`

## Requirements
- R1: While `rst_n` is low at a rising edge, `done`, `result` and `probable_prime` are cleared to zero.
- R2: A high `enable` seen at a rising edge while the block is idle captures `candidate` and starts a test. The end of every test is marked by `done` high for exactly one cycle.
- R3: For an odd candidate p of at least 3, `result` equals BASE^(p-1) mod p. The exponent is scanned over all `CAND_W` bits, from the most significant bit downwards.
- R4: `probable_prime` is 1 exactly when the finished test's `result` equals 1. For every odd candidate of width 8 (all below 341), this matches true primality for the default base of 2.
- R5: A candidate that is even, or that is 0, 1 or 2, is refused. `done` is then high in the cycle right after the enable edge, with `result` = 0 and `probable_prime` = 0.
- R6: `enable` has no effect while a test is running. The test in progress finishes on the candidate it captured, and no extra `done` follows.
- R7: `result` and `probable_prime` change only at the edge that raises `done`. They stay stable from then until the next test completes.
- R8: Every remainder delivered by the divider is less than the captured candidate, so `result` is always less than the candidate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Start request, sampled only while idle |
| candidate | input | CAND_W | Integer to be tested |
| done | output | 1 | One-cycle strobe marking the end of a test |
| result | output | CAND_W | Residue BASE^(p-1) mod p, or 0 for a refused candidate |
| probable_prime | output | 1 | High when the residue equals one |

## Verification
The assertions assume that `enable` and `candidate` are driven to known levels whenever reset is released. They also assume that the base is below 2^CAND_W, so the first step, which reduces the base, sees the intended value. The bench drives every input at the falling clock edge from tasks, holds reset for several edges before releasing it, and keeps the default base of 2. This means the residue check and the primality check are both meaningful for every 8-bit candidate. The enable pulse that arrives during a run is issued only after the block has become busy, so the no-effect property is exercised without racing the capture edge.

// File: rtl/fermat_pkg.sv
// Package: shared sequencing states for the Fermat tester.
// Assumes nothing beyond standard 1800-2017 enum support.
package fermat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_BASE_GO = 3'd1,
        ST_BASE_WT = 3'd2,
        ST_SQ_GO   = 3'd3,
        ST_SQ_WT   = 3'd4,
        ST_MUL_GO  = 3'd5,
        ST_MUL_WT  = 3'd6,
        ST_STEP    = 3'd7
    } fpt_state_t;

endpackage

// File: rtl/fermat_restoring_div.sv
// Module: bit-serial restoring divider returning only the remainder.
// Takes one cycle per dividend bit (2*W cycles) after a start pulse,
// then pulses done with the remainder valid. Assumes divisor != 0 and
// that start is not raised while a division is in progress.
module fermat_restoring_div #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]   divisor,
    output logic           done,
    output logic [W-1:0]   remainder
);
    localparam int PW = 2 * W;
    localparam int CW = $clog2(PW + 1);

    logic [PW-1:0] sh_q;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  dvs_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          done_q;
    logic [W:0]    trial;
    logic [W:0]    diff;

    // Bring down the next dividend bit and form the trial subtraction.
    always_comb begin
        trial = {rem_q, sh_q[PW-1]};
        diff  = trial - {1'b0, dvs_q};
    end

    // Shift, subtract and restore once per cycle while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            rem_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                sh_q   <= dividend;
                rem_q  <= '0;
                dvs_q  <= divisor;
                cnt_q  <= CW'(PW);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                sh_q  <= sh_q << 1;
                rem_q <= diff[W] ? trial[W-1:0] : diff[W-1:0];
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done      = done_q;
    assign remainder = rem_q;

endmodule

// File: rtl/fermat_mulmod.sv
// Module: modular multiplier, (x * y) mod m.
// Forms the full 2*W-bit product in one cycle and reduces it with the
// restoring divider. Assumes x, y < 2^W, m != 0, and operands held
// only for the start cycle (the divider latches them).
module fermat_mulmod #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] m,
    output logic         done,
    output logic [W-1:0] r
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod;

    // Widen both operands so the product keeps every bit.
    always_comb begin
        prod = {{W{1'b0}}, x} * {{W{1'b0}}, y};
    end

    fermat_restoring_div #(.W(W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dividend  (prod),
        .divisor   (m),
        .done      (done),
        .remainder (r)
    );

endmodule

// File: rtl/fermat_prime_tester.sv
// Module: Fermat probable-prime tester, top level.
// Computes BASE^(p-1) mod p by left-to-right square-and-multiply over
// CAND_W exponent bits and flags the candidate when the residue is 1.
// Even candidates and those below 3 are refused in one cycle. Assumes
// BASE < 2^CAND_W; enable is ignored while a test runs.
module fermat_prime_tester #(
    parameter int CAND_W = 8,
    parameter int BASE   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CAND_W-1:0] candidate,
    output logic              done,
    output logic [CAND_W-1:0] result,
    output logic              probable_prime
);
    import fermat_pkg::*;

    localparam int BW = $clog2(CAND_W + 1);
    localparam logic [CAND_W-1:0] BASE_V = CAND_W'(BASE);
    localparam logic [CAND_W-1:0] ONE_V  = CAND_W'(1);

    fpt_state_t        state_q;
    logic [CAND_W-1:0] cand_q;
    logic [CAND_W-1:0] exp_q;
    logic [CAND_W-1:0] acc_q;
    logic [CAND_W-1:0] base_q;
    logic [BW-1:0]     bit_q;
    logic              done_q;
    logic [CAND_W-1:0] result_q;
    logic              prime_q;

    logic              mm_start;
    logic [CAND_W-1:0] mm_x;
    logic [CAND_W-1:0] mm_y;
    logic              mm_done;
    logic [CAND_W-1:0] mm_rem;
    logic              busy;
    logic              refuse;

    // Decide which product the multiplier forms in each launch state.
    always_comb begin
        mm_start = 1'b0;
        mm_x     = acc_q;
        mm_y     = acc_q;
        unique case (state_q)
            ST_BASE_GO: begin
                mm_start = 1'b1;
                mm_x     = ONE_V;
                mm_y     = BASE_V;
            end
            ST_SQ_GO: begin
                mm_start = 1'b1;
            end
            ST_MUL_GO: begin
                mm_start = 1'b1;
                mm_y     = base_q;
            end
            default: begin
                mm_start = 1'b0;
            end
        endcase
    end

    // Flag candidates that the test cannot handle.
    always_comb begin
        refuse = (candidate < CAND_W'(3)) || !candidate[0];
        busy   = (state_q != ST_IDLE);
    end

    fermat_mulmod #(.W(CAND_W)) u_mulmod (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mm_start),
        .x     (mm_x),
        .y     (mm_y),
        .m     (cand_q),
        .done  (mm_done),
        .r     (mm_rem)
    );

    // Sequence base reduction, then square and optional multiply per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cand_q   <= '0;
            exp_q    <= '0;
            acc_q    <= '0;
            base_q   <= '0;
            bit_q    <= '0;
            done_q   <= 1'b0;
            result_q <= '0;
            prime_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (enable) begin
                        cand_q <= candidate;
                        if (refuse) begin
                            result_q <= '0;
                            prime_q  <= 1'b0;
                            done_q   <= 1'b1;
                        end else begin
                            exp_q   <= candidate - ONE_V;
                            acc_q   <= ONE_V;
                            bit_q   <= BW'(CAND_W);
                            state_q <= ST_BASE_GO;
                        end
                    end
                end
                ST_BASE_GO: state_q <= ST_BASE_WT;
                ST_BASE_WT: begin
                    if (mm_done) begin
                        base_q  <= mm_rem;
                        state_q <= ST_SQ_GO;
                    end
                end
                ST_SQ_GO: state_q <= ST_SQ_WT;
                ST_SQ_WT: begin
                    if (mm_done) begin
                        acc_q   <= mm_rem;
                        state_q <= exp_q[CAND_W-1] ? ST_MUL_GO : ST_STEP;
                    end
                end
                ST_MUL_GO: state_q <= ST_MUL_WT;
                ST_MUL_WT: begin
                    if (mm_done) begin
                        acc_q   <= mm_rem;
                        state_q <= ST_STEP;
                    end
                end
                ST_STEP: begin
                    exp_q <= exp_q << 1;
                    bit_q <= bit_q - BW'(1);
                    if (bit_q == BW'(1)) begin
                        result_q <= acc_q;
                        prime_q  <= (acc_q == ONE_V);
                        done_q   <= 1'b1;
                        state_q  <= ST_IDLE;
                    end else begin
                        state_q <= ST_SQ_GO;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done           = done_q;
    assign result         = result_q;
    assign probable_prime = prime_q;

endmodule

// File: rtl/fermat_prime_tester_chk.sv
// Module: property checker bound to the Fermat tester top.
// Assumes inputs are at known levels once reset is released.
module fermat_prime_tester_chk #(
    parameter int CAND_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              busy,
    input logic              done,
    input logic [CAND_W-1:0] result,
    input logic              probable_prime,
    input logic [CAND_W-1:0] cand_q,
    input logic              mm_done,
    input logic [CAND_W-1:0] mm_rem
);
    assert_flag_means_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        probable_prime |-> (result == CAND_W'(1)));

    assert_flag_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (probable_prime == (result == CAND_W'(1))));

    assert_refused_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ((cand_q < CAND_W'(3)) || !cand_q[0])) |-> (!probable_prime && result == '0));

    assert_busy_enable_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && enable) |=> $stable(cand_q));

    assert_outputs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(probable_prime)));

    assert_rem_below_modulus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mm_done |-> (mm_rem < cand_q));

endmodule

bind fermat_prime_tester fermat_prime_tester_chk #(.CAND_W(CAND_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable         (enable),
    .busy           (busy),
    .done           (done),
    .result         (result),
    .probable_prime (probable_prime),
    .cand_q         (cand_q),
    .mm_done        (mm_done),
    .mm_rem         (mm_rem)
);

// File: tb/fermat_prime_tester_test.sv
// Bench: directed scenarios for the Fermat tester, one task each.
module fermat_prime_tester_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic [W-1:0] candidate = '0;
    logic         done;
    logic [W-1:0] result;
    logic         probable_prime;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fermat_prime_tester #(.CAND_W(W), .BASE(2)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (enable),
        .candidate      (candidate),
        .done           (done),
        .result         (result),
        .probable_prime (probable_prime)
    );

    // Record one comparison.
    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_modpow(input int b, input int e, input int m);
        int r = 1;
        for (int i = 0; i < e; i++) r = (r * b) % m;
        return r;
    endfunction

    function automatic int is_prime(input int n);
        if (n < 2) return 0;
        for (int d = 2; d * d <= n; d++) if (n % d == 0) return 0;
        return 1;
    endfunction

    // Wait at falling edges for done; returns falling edges waited.
    task automatic wait_done(output int waited);
        waited = 0;
        while (!done && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        if (!done) begin
            errors++;
            $display("FAIL R2 done never rose actual=0 expected=1");
        end
    endtask

    task automatic pulse_enable(input int c);
        candidate = W'(c);
        enable = 1'b1;
        @(negedge clk);
        enable = 1'b0;
    endtask

    // One full test on candidate c with all output checks.
    task automatic run_one(input int c);
        int waited;
        int er;
        int ep;
        int refused;
        refused = (c < 3) || (c % 2 == 0);
        pulse_enable(c);
        wait_done(waited);
        if (refused) begin
            er = 0;
            ep = 0;
            check("R5", "refusal latency", waited, 0);
            check("R5", "refused result", int'(result), er);
            check("R5", "refused flag", int'(probable_prime), ep);
        end else begin
            er = ref_modpow(2, c - 1, c);
            ep = (er == 1);
            check("R3", $sformatf("residue of %0d", c), int'(result), er);
            check("R4", $sformatf("flag of %0d", c), int'(probable_prime), ep);
            check("R4", $sformatf("primality of %0d", c), int'(probable_prime), is_prime(c));
            check("R8", "result below candidate", int'(result < W'(c)), 1);
        end
        @(negedge clk);
        check("R2", "done width one cycle", int'(done), 0);
    endtask

    task automatic test_reset;
        check("R1", "done after reset", int'(done), 0);
        check("R1", "result after reset", int'(result), 0);
        check("R1", "flag after reset", int'(probable_prime), 0);
    endtask

    task automatic test_known;
        run_one(149);
        run_one(41);
        run_one(9);
        run_one(91);
        run_one(221);
        run_one(255);
        run_one(3);
        run_one(251);
    endtask

    task automatic test_refusals;
        run_one(0);
        run_one(1);
        run_one(2);
        run_one(200);
    endtask

    task automatic test_sweep;
        for (int c = 0; c < 256; c++) run_one(c);
    endtask

    task automatic test_busy_ignore;
        int waited;
        int extra;
        pulse_enable(149);
        repeat (20) @(negedge clk);
        pulse_enable(9);
        wait_done(waited);
        check("R6", "residue kept for first candidate", int'(result), 1);
        check("R6", "flag kept for first candidate", int'(probable_prime), 1);
        extra = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check("R6", "no extra done", extra, 0);
    endtask

    task automatic test_hold;
        int waited;
        int seen;
        pulse_enable(15);
        wait_done(waited);
        seen = int'(result);
        check("R3", "residue of 15", seen, ref_modpow(2, 14, 15));
        candidate = W'(41);
        repeat (50) @(negedge clk);
        check("R7", "result held", int'(result), seen);
        check("R7", "flag held", int'(probable_prime), 0);
    endtask

    task automatic report;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_known();
        test_refusals();
        test_busy_ignore();
        test_hold();
        test_sweep();
        report();
    end

endmodule